// File: doc/BRIEF.md
# Color Table Burst Loader

This block owns a 256-word by 16-bit color table and lets a processor fill it through one write port. The processor first writes a header word that holds a start index and a word count. Each later write stores one color word at the current index and moves the index forward by one, until the count runs out. The write after that is taken as a new header. No separate address register is needed, so the processor can reload any run of entries with a single port.

A status word on the same port shows whether the loader still expects data words and how many remain. The display side has its own read port. It takes an index and returns that entry one clock later. When the display reads an entry in the same cycle that the processor writes it, the display gets the new value. Color conversion and the rest of the display path lie outside this block.

Top module: `pal_burst_port`

## Requirements
- R1: When reset is asserted, with or without a burst in flight, the loader returns to the header-expected state and the status word reads 0x0000.
- R2: A write while idle is a header. Bits 15..8 are the start index and bits 7..0 are the word count. A nonzero count makes the status busy bit 1 and sets the remaining count to that count.
- R3: A write while busy stores the 16-bit word at the current index, then moves the index up by one.
- R4: Each data write lowers the remaining count by one. After the last counted word the loader is idle again, and the next write is treated as a header.
- R5: A header whose count is 0 leaves the loader idle and stores nothing.
- R6: During a burst the index wraps from 255 to 0.
- R7: The status word has the busy flag in bit 0 and the remaining count in bits 15..8. Bits 7..1 read 0. The status changes only on a port write or on reset.
- R8: The display read port returns the entry at `vid_rd_addr` on `vid_rd_data` one clock after the address is presented.
- R9: If a display read and a data write hit the same index in the same cycle, the display read returns the newly written word.
- R10: A header write leaves every table entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Port write strobe, one word per cycle |
| cpu_wr_data | input | 16 | Header or color word |
| cpu_status | output | 16 | Status: remaining count in [15:8], busy flag in [0] |
| vid_rd_addr | input | 8 | Display-side read index |
| vid_rd_data | output | 16 | Display-side read data, one cycle latency |

## Verification
The bench targets five cases:
- A count of 255 starting at index 0, followed by a one-word burst at 255. An off-by-one in the counter would either run into the next header or stop one word short, and the readback of all entries would show it.
- A burst from index 254 that crosses the top of the table. A design that saturates the index instead of wrapping would overwrite 255 instead of filling 0 and 1.
- A zero-count header followed by another header. A design that treats zero as 256 would store the second header as a color.
- A display read of the same index that a write hits in that cycle. A read-first table would return the stale word.
- A reset in the middle of a burst. The bench checks that the next write is handled as a header.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int unsigned IDX_W  = 8;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned CNT_W  = 8;

    typedef struct packed {
        logic [IDX_W-1:0] dst;
        logic [CNT_W-1:0] len;
    } hdr_t;

    typedef enum logic {
        ST_HEADER = 1'b0,
        ST_DATA   = 1'b1
    } ld_state_e;

    typedef struct packed {
        ld_state_e        state;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] remain;
    } ld_ctx_t;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  addr;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic hdr_t split_hdr(input logic [WORD_W-1:0] w);
        hdr_t h;
        h.dst = w[WORD_W-1 -: IDX_W];
        h.len = w[CNT_W-1:0];
        return h;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input ld_ctx_t c);
        logic [WORD_W-1:0] s;
        s = '0;
        s[WORD_W-1 -: CNT_W] = c.remain;
        s[0] = (c.state == ST_DATA);
        return s;
    endfunction

    localparam ld_ctx_t CTX_RESET = '{state: ST_HEADER, idx: '0, remain: '0};

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output wr_req_t           req,
    output ld_ctx_t           ctx
);

    ld_ctx_t ctx_q, ctx_d;
    hdr_t    hdr;

    assign hdr = split_hdr(wr_data);

    always_comb begin
        ctx_d    = ctx_q;
        req.we   = 1'b0;
        req.addr = ctx_q.idx;
        req.data = wr_data;
        if (wr_en) begin
            unique case (ctx_q.state)
                ST_HEADER: begin
                    ctx_d.idx    = hdr.dst;
                    ctx_d.remain = hdr.len;
                    ctx_d.state  = (hdr.len != '0) ? ST_DATA : ST_HEADER;
                end
                ST_DATA: begin
                    req.we       = 1'b1;
                    ctx_d.idx    = ctx_q.idx + 1'b1;
                    ctx_d.remain = ctx_q.remain - 1'b1;
                    ctx_d.state  = (ctx_q.remain == CNT_W'(1)) ? ST_HEADER : ST_DATA;
                end
                default: ctx_d = CTX_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctx_q <= CTX_RESET;
        else     ctx_q <= ctx_d;
    end

    assign ctx = ctx_q;

endmodule

// File: rtl/pal_ram.sv
module pal_ram
    import pal_pkg::*;
#(
    parameter int unsigned AW          = IDX_W,
    parameter int unsigned DW          = WORD_W,
    parameter bit          WRITE_FIRST = 1'b1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    generate
        if (WRITE_FIRST) begin : g_bypass
            always_ff @(posedge clk) begin
                if (we && (waddr == raddr)) rd_q <= wdata;
                else                        rd_q <= mem[raddr];
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                rd_q <= mem[raddr];
            end
        end
    endgenerate

    assign rdata = rd_q;

endmodule

// File: rtl/pal_burst_port.sv
module pal_burst_port
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr_en,
    input  logic [WORD_W-1:0] cpu_wr_data,
    output logic [WORD_W-1:0] cpu_status,
    input  logic [IDX_W-1:0]  vid_rd_addr,
    output logic [WORD_W-1:0] vid_rd_data
);

    wr_req_t seq_req;
    ld_ctx_t seq_ctx;

    pal_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cpu_wr_en),
        .wr_data (cpu_wr_data),
        .req     (seq_req),
        .ctx     (seq_ctx)
    );

    pal_ram #(
        .AW          (IDX_W),
        .DW          (WORD_W),
        .WRITE_FIRST (1'b1)
    ) u_ram (
        .clk   (clk),
        .we    (seq_req.we),
        .waddr (seq_req.addr),
        .wdata (seq_req.data),
        .raddr (vid_rd_addr),
        .rdata (vid_rd_data)
    );

    assign cpu_status = pack_status(seq_ctx);

endmodule

// File: rtl/pal_burst_port_chk.sv
module pal_burst_port_chk
    import pal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_wr_en,
    input logic [WORD_W-1:0] cpu_wr_data,
    input logic [WORD_W-1:0] cpu_status,
    input wr_req_t           seq_req
);

    logic             busy;
    logic [CNT_W-1:0] remain;

    assign busy   = cpu_status[0];
    assign remain = cpu_status[WORD_W-1 -: CNT_W];

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (cpu_status == '0));

    a_r2_header_arms: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_en && !busy && (cpu_wr_data[CNT_W-1:0] != '0))
        |=> (busy && (remain == $past(cpu_wr_data[CNT_W-1:0]))));

    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_en && busy) |=> (remain == $past(remain) - 1'b1));

    a_r5_zero_len_idle: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_en && !busy && (cpu_wr_data[CNT_W-1:0] == '0)) |=> !busy);

    a_r7_status_hold: assert property (@(posedge clk) disable iff (rst)
        !cpu_wr_en |=> $stable(cpu_status));

    a_r10_store_only_busy: assert property (@(posedge clk) disable iff (rst)
        seq_req.we |-> (busy && cpu_wr_en));

endmodule

bind pal_burst_port pal_burst_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_data (cpu_wr_data),
    .cpu_status  (cpu_status),
    .seq_req     (seq_req)
);

// File: tb/pal_burst_port_test.sv
module pal_burst_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_wr_data = '0;
    logic [15:0] cpu_status;
    logic [7:0]  vid_rd_addr = '0;
    logic [15:0] vid_rd_data;

    int n_checks = 0;
    int n_fail = 0;

    logic [15:0] m_mem [256];
    bit          m_known [256];
    bit          m_busy = 0;
    int          m_idx = 0;
    int          m_rem = 0;

    always #5 clk = ~clk;

    pal_burst_port uut (
        .clk         (clk),
        .rst         (rst),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_wr_data (cpu_wr_data),
        .cpu_status  (cpu_status),
        .vid_rd_addr (vid_rd_addr),
        .vid_rd_data (vid_rd_data)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        return {8'(m_rem), 7'b0, m_busy};
    endfunction

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        cpu_wr_en = 1'b0;
        repeat (cycles) @(posedge clk);
        m_busy = 0; m_idx = 0; m_rem = 0;
        #1;
        check("R1 status after reset", cpu_status, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input bit wr, input logic [15:0] d, input logic [7:0] ra, input string tag);
        logic [15:0] exp_rd;
        bit          known;
        bit          hit;
        bit          we;
        @(negedge clk);
        cpu_wr_en = wr;
        cpu_wr_data = d;
        vid_rd_addr = ra;
        @(posedge clk);
        we = wr && m_busy;
        hit = we && (m_idx == int'(ra));
        exp_rd = hit ? d : m_mem[ra];
        known = hit || m_known[ra];
        if (wr) begin
            if (!m_busy) begin
                m_idx = int'(d[15:8]);
                m_rem = int'(d[7:0]);
                m_busy = (m_rem != 0);
            end else begin
                m_mem[m_idx] = d;
                m_known[m_idx] = 1;
                m_idx = (m_idx + 1) % 256;
                m_rem = m_rem - 1;
                m_busy = (m_rem != 0);
            end
        end
        #1;
        check({tag, " status R7"}, cpu_status, exp_status());
        if (known) check(hit ? "R9 collision read" : {tag, " read R8"}, vid_rd_data, exp_rd);
    endtask

    initial begin : watchdog
        #1ms;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 256; i++) m_known[i] = 0;
        do_reset(2);

        // R2 / R3: fill 0..254, read back lagging addresses
        step(1, 16'h00FF, 8'h00, "R2");
        check("R2 busy after header", cpu_status, 16'hFF01);
        for (int i = 0; i < 255; i++)
            step(1, 16'(i * 37 + 16'h1234), 8'(i > 0 ? i - 1 : 0), "R3");
        check("R4 idle after count", cpu_status, 16'h0000);
        // R4: next write is header again, one word at 255
        step(1, 16'hFF01, 8'hFE, "R4");
        step(1, 16'hBEEF, 8'hFF, "R4");
        for (int i = 0; i < 256; i++) step(0, 16'h0, 8'(i), "R8");

        // R5: zero-length header, then a real header
        step(1, 16'h1000, 8'h10, "R5");
        check("R5 zero length idle", cpu_status, 16'h0000);
        step(1, 16'h2002, 8'h20, "R5");
        check("R5 following write is header", cpu_status, 16'h0201);
        step(1, 16'hAAAA, 8'h20, "R3");
        step(1, 16'h5555, 8'h21, "R3");

        // R6: wrap 254..1
        step(1, 16'hFE04, 8'hFE, "R6");
        step(1, 16'h0F0E, 8'h00, "R6");
        step(1, 16'h0F0F, 8'h01, "R6");
        step(1, 16'h0F00, 8'hFE, "R6");
        step(1, 16'h0F01, 8'hFF, "R6");
        for (int i = 0; i < 4; i++) step(0, 16'h0, 8'(i), "R6");
        step(0, 16'h0, 8'hFE, "R6");
        step(0, 16'h0, 8'hFF, "R6");

        // R9: same-index collisions
        step(1, 16'h4003, 8'h40, "R10");
        step(1, 16'hC001, 8'h40, "R9");
        step(1, 16'hC002, 8'h41, "R9");
        step(1, 16'hC003, 8'h42, "R9");
        step(0, 16'h0, 8'h41, "R9");

        // R10: header aimed at a known entry leaves it alone
        step(1, 16'h4102, 8'h41, "R10");
        step(0, 16'h0, 8'h41, "R10");
        check("R10 entry unchanged by header", vid_rd_data, 16'hC002);

        // R1: reset mid-burst, then next write is a header
        step(1, 16'h3005, 8'h30, "R1");
        do_reset(1);
        step(1, 16'h3101, 8'h31, "R1");
        check("R1 header after mid-burst reset", cpu_status, 16'h0101);
        step(1, 16'h7777, 8'h31, "R1");
        step(0, 16'h0, 8'h31, "R1");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule